// File: doc/BRIEF.md
# Fractional Divide Ratio Calculator

This block turns a target ratio v/x, such as an oscillator frequency over a reference frequency or over an output frequency, into the mixed fraction a + b/c. That fraction programs a fractional-N synthesizer divider. The integer part a is full width. The fraction b/c uses 20-bit fields, with c never above 0xFFFFF.

The block first computes a trial numerator against the largest 20-bit denominator. It then recomputes the denominator from that truncated numerator. Because the denominator can move in much finer steps than the numerator, the result is usually far closer to the exact fraction than a fixed-denominator result.

All three divisions share one serial restoring divider. The divider accepts dividends up to 64 bits and yields one quotient bit per clock, so one request takes a few hundred cycles.

The request side is a valid/ready port. `req_ready` is high only while the block is idle. A request is taken on the edge where `req_valid` and `req_ready` are both high, and any input activity at other times is ignored. The result side has no back-pressure. `res_valid` is high for exactly one cycle, and the result fields then hold their values until the next result is produced, so a consumer may also read them later.

Top module: `frac_ratio_calc`

## Requirements
- R1: For a divisor x that is not zero, the result integer part equals floor(v / x).
- R2: When x is not zero and v mod x is 0, the result is b = 0 and c = 1.
- R3: When r = v mod x is not zero, the trial numerator is b0 = floor(r * 0xFFFFF / x), and the result numerator is always b0.
- R4: The corrected denominator is c1 = floor(b0 * x / r). When c1 <= 0xFFFFF and c1 > b0, the result denominator is c1.
- R5: When c1 > 0xFFFFF or c1 <= b0, the result denominator is 0xFFFFF, so the uncorrected pair is kept.
- R6: A request with x = 0 returns a = 0xFFFFFFFF (all ones), b = 0 and c = 1.
- R7: Every result satisfies 1 <= c <= 0xFFFFF and b < c.
- R8: `res_valid` is high for exactly one cycle per accepted request. The result fields hold their values in every cycle in which `res_valid` is low.
- R9: `req_ready` is low in the cycle after a request is accepted and stays low until the result is delivered. `req_valid`, `req_num` and `req_den` are ignored while `req_ready` is low.
- R10: After reset, `req_ready` = 1, `res_valid` = 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle when req_valid is also high |
| req_num | input | 32 | Ratio numerator v |
| req_den | input | 32 | Ratio denominator x |
| res_valid | output | 1 | One-cycle result strobe |
| res_int | output | 32 | Integer part a |
| res_frac_num | output | 20 | Fraction numerator b |
| res_frac_den | output | 20 | Fraction denominator c |

## Verification
Several ratio classes are driven. Exact multiples and a zero numerator separate the early exit from the fraction path. Small remainders over large divisors, such as 1/1000, show whether the recomputed denominator is actually adopted. Near-unity remainders, such as 0xFFFFFFFF over 0x80000000, give a corrected value equal to the trial numerator, which must fall back to 0xFFFFF. A tiny remainder over a huge divisor gives a trial numerator of zero. A zero divisor, a set of pseudo-random ratios, and junk held on the request port while the block is busy complete the set.

// File: rtl/ratio_calc_pkg.sv
package ratio_calc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_FRAC,
    ST_CORR,
    ST_FINISH
  } calc_state_t;
endpackage

// File: rtl/ratio_operands.sv
// Forms the dividends for the trial-numerator and correction divides.
module ratio_operands #(
  parameter int NUM_W  = 32,
  parameter int FRAC_W = 20,
  parameter int DVD_W  = 64
) (
  input  logic [NUM_W-1:0]  rem_val,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [NUM_W-1:0]  den,
  output logic [DVD_W-1:0]  scaled_rem,
  output logic [DVD_W-1:0]  back_prod
);
  localparam int PROD_W = NUM_W + FRAC_W;

  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] back;

  // rem * (2^FRAC_W - 1) as a shift and a subtract
  assign scaled = {rem_val, {FRAC_W{1'b0}}} - {{FRAC_W{1'b0}}, rem_val};
  assign back   = {{FRAC_W{1'b0}}, den} * {{NUM_W{1'b0}}, frac_num};

  assign scaled_rem = DVD_W'(scaled);
  assign back_prod  = DVD_W'(back);
endmodule

// File: rtl/ratio_div_serial.sv
// Restoring divider: one quotient bit per clock, quotient and remainder together.
module ratio_div_serial #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q;
  logic [DVD_W-1:0] shf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             take;

  always_comb begin
    trial = {rem_q, shf_q[DVD_W-1]};
    diff  = trial - {1'b0, divisor};
    take  = (trial >= {1'b0, divisor});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      shf_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        shf_q <= dividend;
        cnt_q <= CNT_W'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        shf_q <= {shf_q[DVD_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done      = done_q;
  assign quotient  = shf_q;
  assign remainder = rem_q;
endmodule

// File: rtl/frac_ratio_calc.sv
module frac_ratio_calc #(
  parameter int NUM_W  = 32,
  parameter int FRAC_W = 20,
  parameter int DVD_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [NUM_W-1:0]  req_den,
  output logic              res_valid,
  output logic [NUM_W-1:0]  res_int,
  output logic [FRAC_W-1:0] res_frac_num,
  output logic [FRAC_W-1:0] res_frac_den
);
  import ratio_calc_pkg::*;

  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
  localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);

  calc_state_t       state_q;
  logic [NUM_W-1:0]  den_q;
  logic [NUM_W-1:0]  rem_q;
  logic [NUM_W-1:0]  int_st_q;
  logic [FRAC_W-1:0] b_st_q;
  logic [FRAC_W-1:0] c_st_q;
  logic              div_go_q;
  logic [DVD_W-1:0]  div_dvd_q;
  logic [NUM_W-1:0]  div_dvs_q;
  logic              res_valid_q;
  logic [NUM_W-1:0]  res_int_q;
  logic [FRAC_W-1:0] res_b_q;
  logic [FRAC_W-1:0] res_c_q;

  logic              div_done;
  logic [DVD_W-1:0]  div_quot;
  logic [NUM_W-1:0]  div_rem;
  logic [DVD_W-1:0]  scaled_rem;
  logic [DVD_W-1:0]  back_prod;
  logic              req_fire;
  logic              corr_fits;
  logic              corr_above;

  assign req_ready  = (state_q == ST_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign corr_fits  = ~|div_quot[DVD_W-1:FRAC_W];
  assign corr_above = div_quot[FRAC_W-1:0] > b_st_q;

  ratio_operands #(
    .NUM_W (NUM_W),
    .FRAC_W(FRAC_W),
    .DVD_W (DVD_W)
  ) u_operands (
    .rem_val   (div_rem),
    .frac_num  (div_quot[FRAC_W-1:0]),
    .den       (den_q),
    .scaled_rem(scaled_rem),
    .back_prod (back_prod)
  );

  ratio_div_serial #(
    .DVD_W(DVD_W),
    .DVS_W(NUM_W)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go_q),
    .dividend (div_dvd_q),
    .divisor  (div_dvs_q),
    .done     (div_done),
    .quotient (div_quot),
    .remainder(div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      den_q       <= '0;
      rem_q       <= '0;
      int_st_q    <= '0;
      b_st_q      <= '0;
      c_st_q      <= '0;
      div_go_q    <= 1'b0;
      div_dvd_q   <= '0;
      div_dvs_q   <= '0;
      res_valid_q <= 1'b0;
      res_int_q   <= '0;
      res_b_q     <= '0;
      res_c_q     <= '0;
    end else begin
      div_go_q    <= 1'b0;
      res_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            den_q <= req_den;
            if (req_den == '0) begin
              int_st_q <= '1;
              b_st_q   <= '0;
              c_st_q   <= FRAC_ONE;
              state_q  <= ST_FINISH;
            end else begin
              div_dvd_q <= DVD_W'(req_num);
              div_dvs_q <= req_den;
              div_go_q  <= 1'b1;
              state_q   <= ST_INT;
            end
          end
        end
        ST_INT: begin
          if (div_done) begin
            int_st_q <= div_quot[NUM_W-1:0];
            rem_q    <= div_rem;
            if (div_rem == '0) begin
              b_st_q  <= '0;
              c_st_q  <= FRAC_ONE;
              state_q <= ST_FINISH;
            end else begin
              div_dvd_q <= scaled_rem;
              div_dvs_q <= den_q;
              div_go_q  <= 1'b1;
              state_q   <= ST_FRAC;
            end
          end
        end
        ST_FRAC: begin
          if (div_done) begin
            b_st_q    <= div_quot[FRAC_W-1:0];
            div_dvd_q <= back_prod;
            div_dvs_q <= rem_q;
            div_go_q  <= 1'b1;
            state_q   <= ST_CORR;
          end
        end
        ST_CORR: begin
          if (div_done) begin
            c_st_q  <= (corr_fits && corr_above) ? div_quot[FRAC_W-1:0] : FRAC_MAX;
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          res_int_q   <= int_st_q;
          res_b_q     <= b_st_q;
          res_c_q     <= c_st_q;
          res_valid_q <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid    = res_valid_q;
  assign res_int      = res_int_q;
  assign res_frac_num = res_b_q;
  assign res_frac_den = res_c_q;
endmodule

// File: rtl/frac_ratio_calc_chk.sv
module frac_ratio_calc_chk #(
  parameter int NUM_W  = 32,
  parameter int FRAC_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic [NUM_W-1:0]  res_int,
  input logic [FRAC_W-1:0] res_frac_num,
  input logic [FRAC_W-1:0] res_frac_den
);
  AST_FRAC_PROPER: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_frac_num < res_frac_den); // R7

  AST_DEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_frac_den != '0); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_int) && $stable(res_frac_num) && $stable(res_frac_den))); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

  AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready); // R9
endmodule

bind frac_ratio_calc frac_ratio_calc_chk #(
  .NUM_W (NUM_W),
  .FRAC_W(FRAC_W)
) u_frac_ratio_calc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .res_valid   (res_valid),
  .res_int     (res_int),
  .res_frac_num(res_frac_num),
  .res_frac_den(res_frac_den)
);

// File: tb/test_frac_ratio_calc.sv
`timescale 1ns/1ps
module test_frac_ratio_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_num = '0;
  logic [31:0] req_den = '0;
  logic        res_valid;
  logic [31:0] res_int;
  logic [19:0] res_frac_num;
  logic [19:0] res_frac_den;

  typedef struct {
    logic [31:0] a;
    logic [19:0] b;
    logic [19:0] c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   total = 0;
  int   bad = 0;
  bit   done_flag = 0;

  always #5 clk = ~clk;

  frac_ratio_calc i_frac_ratio_calc (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_num     (req_num),
    .req_den     (req_den),
    .res_valid   (res_valid),
    .res_int     (res_int),
    .res_frac_num(res_frac_num),
    .res_frac_den(res_frac_den)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  // Expected result from the requirements
  function automatic exp_t model(input logic [31:0] v, input logic [31:0] x);
    exp_t e;
    logic [63:0] r, b0, c1;
    if (x == 0) begin
      e.a = '1; e.b = 0; e.c = 1; e.tag = "R6";
    end else begin
      e.a = v / x;
      r = 64'(v % x);
      if (r == 0) begin
        e.b = 0; e.c = 1; e.tag = "R1 R2";
      end else begin
        b0 = (r * 64'hFFFFF) / 64'(x);
        c1 = (b0 * 64'(x)) / r;
        e.b = b0[19:0];
        if (c1 <= 64'hFFFFF && c1 > b0) begin
          e.c = c1[19:0]; e.tag = "R1 R3 R4";
        end else begin
          e.c = 20'hFFFFF; e.tag = "R1 R3 R5";
        end
      end
    end
    return e;
  endfunction

  // Driver: push expected, issue request, optionally poke the port while busy
  task automatic send(input logic [31:0] v, input logic [31:0] x, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(model(v, x));
    req_valid = 1'b1;
    req_num   = v;
    req_den   = x;
    @(negedge clk);
    req_num = ~v;
    req_den = x + 32'd3;
    req_valid = poke;
    check(req_ready == 1'b0, "R9", "ready low after accept", 64'(req_ready), 64'd0);
    if (poke) begin
      repeat (10) @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready low while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pop and compare on every result strobe
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected result", 64'(res_int), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_int == e.a, e.tag, "integer part", 64'(res_int), 64'(e.a));
        check(res_frac_num == e.b, e.tag, "fraction numerator", 64'(res_frac_num), 64'(e.b));
        check(res_frac_den == e.c, e.tag, "fraction denominator", 64'(res_frac_den), 64'(e.c));
        check(res_frac_num < res_frac_den && res_frac_den != 0, "R7", "proper fraction",
              64'(res_frac_num), 64'(res_frac_den));
        last_exp = e;
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      check(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);
    check(res_valid == 1'b0, "R10", "valid after reset", 64'(res_valid), 64'd0);
    check(res_int == 0 && res_frac_num == 0 && res_frac_den == 0, "R10", "fields after reset",
          {res_int, 12'd0, res_frac_num}, 64'd0);

    send(32'd900000000, 32'd27000000, 1'b0);
    send(32'd1, 32'd1000, 1'b0);                 // R4 corrected denominator
    send(32'd999, 32'd1000, 1'b0);
    send(32'd135000000, 32'd27000000, 1'b0);     // R2 exact multiple
    send(32'd0, 32'd7, 1'b0);                    // R2 zero numerator
    send(32'd12345, 32'd0, 1'b0);                // R6 zero divisor
    send(32'd1, 32'hFFFFFFFF, 1'b0);             // R5 trial numerator zero
    send(32'hFFFFFFFF, 32'h80000000, 1'b0);      // R5 correction equals trial
    send(32'hFFFFFFFF, 32'd1, 1'b0);             // R2
    send(32'd7, 32'd3, 1'b1);                    // R9 junk while busy
    send(32'd3, 32'd7, 1'b0);

    lfsr = 32'h1F3A_9C45;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] v, x;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      v = lfsr;
      x = (lfsr >> (i % 24)) | 32'd1;
      send(v, x, 1'b0);
    end

    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    // R8: fields hold after the strobe
    repeat (5) begin
      @(negedge clk);
      check(res_valid == 1'b0, "R8", "strobe low when idle", 64'(res_valid), 64'd0);
      check(res_int == last_exp.a && res_frac_num == last_exp.b && res_frac_den == last_exp.c,
            "R8", "result held", 64'(res_frac_den), 64'(last_exp.c));
    end
    done_flag = 1;
    finish_run();
  end
endmodule